// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a switch CPU port. Frames arrive as a stream of 32-bit words, each marked with a last flag. On the last word the stream also carries a count of valid tail bytes, the source switch port, a checksum-error flag and a VLAN-tag flag. The engine keeps a pointer into a ring of four-word descriptors held in host memory. When a frame begins, it reads the first word of the current descriptor. If software has handed that descriptor to hardware, the engine writes the payload into the buffer the descriptor names. It then writes a status word with the length and flags, and writes the first word back with only the ownership bit cleared. Finally it raises a receive interrupt and moves to the next descriptor, going back to the ring base when the descriptor carries the ring-end mark.

When the current descriptor still belongs to software, the engine consumes the whole frame without touching memory and raises a descriptor-full interrupt. Frames longer than the buffer are cut at the buffer size and flagged as errors. Every memory access uses one request/acknowledge port: a request is held until the memory acknowledges it, and read data arrives together with the acknowledge.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset `mem_req`, `in_ready`, `irq_rx` and `irq_full` are all 0.
- R2: When a frame starts, the engine reads word 0 of the current descriptor. For the first frame after reset this word is at `ring_base`. If bit 31 of that word (the ownership bit) is 1, word k of the frame is written to address (word0[23:0] + 4k).
- R3: After the last payload word, the status word is written at descriptor + 12. Its layout is: bits 26:16 hold the length in bytes, counted as 4·(words−1) plus the tail count (tail code 0 means 4), so any CRC bytes are included. Bits 14:12 hold the source port. Bit 3 is the error flag and bit 2 is the tag flag. All other bits are 0.
- R4: After the status write, word 0 of the descriptor is written back with bit 31 cleared and bits 30:0 unchanged.
- R5: The next descriptor is at descriptor + 16. If bit 28 of word 0 was set, the next descriptor is at `ring_base` instead.
- R6: If bit 31 of word 0 is 0, the frame is accepted word by word with no memory write. `irq_full` is set, and the next frame uses the same descriptor.
- R7: Words beyond BUF_WORDS are accepted but not written. The length is capped at 4·BUF_WORDS and status bit 3 is set.
- R8: `irq_rx` rises in the cycle after the acknowledge of the ownership write. It stays at 1 until a cycle with `irq_rx_ack` high.
- R9: `irq_full` stays at 1 until a cycle with `irq_full_ack` high.
- R10: While `mem_req` is high and `mem_ack` is low, the request, direction, address and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ring_base | input | 24 | Byte address of the first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the request |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted |
| in_data | input | 32 | Stream word |
| in_last | input | 1 | Last word of the frame |
| in_tail | input | 2 | Valid bytes in the last word, 0 means 4 |
| in_port | input | 3 | Source switch port, on the last word |
| in_err | input | 1 | Checksum error, on the last word |
| in_tag | input | 1 | VLAN tag seen, on the last word |
| irq_rx | output | 1 | Frame stored interrupt |
| irq_rx_ack | input | 1 | Clears irq_rx |
| irq_full | output | 1 | Frame dropped interrupt |
| irq_full_ack | input | 1 | Clears irq_full |

## Verification
The bench sends four kinds of frame into a three-descriptor ring:
- A multi-word frame with a partial tail and the tag flag set. It checks the buffer addressing and the length formula.
- A one-word frame with the error flag set. It checks the error bit and the step to the next descriptor.
- A frame longer than the buffer, placed in the ring-end descriptor. It separates truncation from normal storage and shows the wrap to the base.
- A frame that meets a released descriptor. It must cause no write at all and must leave the pointer in place, which the bench confirms once ownership is handed back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int ADDR_W   = 24;
    localparam int LEN_W    = 11;
    localparam int OWN_BIT  = 31;
    localparam int END_BIT  = 28;
    localparam int IRQ_RX   = 0;
    localparam int IRQ_FULL = 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WR, ST_DROP, ST_STAT, ST_REL
    } st_e;

    function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                                input logic [2:0] port,
                                                input logic err, input logic tag);
        logic [31:0] s;
        s = '0;
        s[26:16] = len;
        s[14:12] = port;
        s[3]     = err;
        s[2]     = tag;
        return s;
    endfunction
endpackage

// File: rtl/rxr_irq_flag.sv
module rxr_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/rxr_len_acc.sv
module rxr_len_acc #(
    parameter int BUF_WORDS = 388
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     add,
    input  logic                     last,
    input  logic [1:0]               tail,
    output logic [rxr_pkg::LEN_W-1:0] len
);
    localparam int CAP   = BUF_WORDS * 4;
    localparam int BYT_W = rxr_pkg::LEN_W + 2;

    logic [BYT_W-1:0] bytes_d, bytes_q;
    logic [2:0]       inc;

    always_comb begin
        inc = 3'd4;
        if (last && tail != 2'd0) inc = {1'b0, tail};
        bytes_d = bytes_q;
        if (clr)
            bytes_d = '0;
        else if (add && bytes_q <= BYT_W'(CAP))
            bytes_d = bytes_q + BYT_W'(inc);
        if (bytes_q > BYT_W'(CAP)) len = rxr_pkg::LEN_W'(CAP);
        else                       len = bytes_q[rxr_pkg::LEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bytes_q <= '0;
        else        bytes_q <= bytes_d;
    end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int BUF_WORDS = 388
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    input  logic              in_last,
    input  logic [1:0]        in_tail,
    input  logic [2:0]        in_port,
    input  logic              in_err,
    input  logic              in_tag,
    output logic              irq_rx,
    input  logic              irq_rx_ack,
    output logic              irq_full,
    input  logic              irq_full_ack
);
    localparam int CW = $clog2(BUF_WORDS + 1);
    localparam logic [CW-1:0] WMAX = CW'(BUF_WORDS);

    typedef struct packed {
        st_e              st;
        logic             ptr_ok;
        logic [ADDR_W-1:0] desc;
        logic [31:0]      buf1;
        logic [CW-1:0]    words;
        logic             trunc;
        logic             err;
        logic             tag;
        logic [2:0]       port;
    } regs_t;

    regs_t r_d, r_q;
    logic  acc_clr, acc_add;
    logic [LEN_W-1:0] len;
    logic [1:0] irq_set, irq_clr, irq_q;
    logic [ADDR_W-1:0] cur;

    rxr_len_acc #(.BUF_WORDS(BUF_WORDS)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
        .last(in_last), .tail(in_tail), .len(len)
    );

    assign irq_clr[IRQ_RX]   = irq_rx_ack;
    assign irq_clr[IRQ_FULL] = irq_full_ack;

    for (genvar g = 0; g < 2; g++) begin : g_irq
        rxr_irq_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(irq_set[g]), .clr(irq_clr[g]), .flag(irq_q[g])
        );
    end

    assign irq_rx   = irq_q[IRQ_RX];
    assign irq_full = irq_q[IRQ_FULL];

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.desc;
        mem_wdata = '0;
        in_ready  = 1'b0;
        irq_set   = '0;
        acc_clr   = 1'b0;
        acc_add   = 1'b0;
        cur       = r_q.ptr_ok ? r_q.desc : ring_base;

        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.desc   = cur;
                    r_d.ptr_ok = 1'b1;
                    r_d.words  = '0;
                    r_d.trunc  = 1'b0;
                    acc_clr    = 1'b1;
                    r_d.st     = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.buf1 = mem_rdata;
                    r_d.st   = mem_rdata[OWN_BIT] ? ST_WR : ST_DROP;
                end
            end
            ST_WR: begin
                if (in_valid) begin
                    if (r_q.words < WMAX) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = r_q.buf1[ADDR_W-1:0] + (ADDR_W'(r_q.words) << 2);
                        mem_wdata = in_data;
                        in_ready  = mem_ack;
                    end else begin
                        in_ready  = 1'b1;
                        r_d.trunc = 1'b1;
                    end
                end
                if (in_valid && in_ready) begin
                    acc_add = 1'b1;
                    if (r_q.words < WMAX) r_d.words = r_q.words + 1'b1;
                    if (in_last) begin
                        r_d.port = in_port;
                        r_d.err  = in_err;
                        r_d.tag  = in_tag;
                        r_d.st   = ST_STAT;
                    end
                end
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    irq_set[IRQ_FULL] = 1'b1;
                    r_d.st = ST_IDLE;
                end
            end
            ST_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.desc + ADDR_W'(12);
                mem_wdata = pack_status(len, r_q.port, r_q.err | r_q.trunc, r_q.tag);
                if (mem_ack) r_d.st = ST_REL;
            end
            ST_REL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.buf1;
                mem_wdata[OWN_BIT] = 1'b0;
                if (mem_ack) begin
                    irq_set[IRQ_RX] = 1'b1;
                    r_d.desc = r_q.buf1[END_BIT] ? ring_base : r_q.desc + ADDR_W'(16);
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk
    import rxr_pkg::*;
#(
    parameter int BUF_WORDS = 388,
    parameter int CW = $clog2(BUF_WORDS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic              irq_rx,
    input logic              irq_rx_ack,
    input logic              irq_full,
    input logic              irq_full_ack,
    input st_e               st,
    input logic [CW-1:0]     words
);
    // R10: request held steady until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R8: receive interrupt only follows an acknowledged write
    a_r8_rx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> $past(mem_req && mem_we && mem_ack));

    // R8: acknowledge clears when no new set
    a_r8_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_ack && !(st == ST_REL && mem_ack) |=> !irq_rx);

    // R9: acknowledge clears the full interrupt when no new drop ends
    a_r9_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        irq_full_ack && !(st == ST_DROP && in_valid && in_last) |=> !irq_full);

    // R6: full interrupt follows the last accepted word of a frame
    a_r6_full_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_full) |-> $past(in_valid && in_ready && in_last));

    // R6: dropping a frame makes no memory access
    a_r6_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DROP |-> !mem_req);

    // R7: payload writes stay inside the buffer
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_WR && mem_req |-> words < CW'(BUF_WORDS));
endmodule

bind rx_ring_engine rx_ring_engine_chk #(.BUF_WORDS(BUF_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .irq_rx(irq_rx), .irq_rx_ack(irq_rx_ack), .irq_full(irq_full),
    .irq_full_ack(irq_full_ack), .st(r_q.st), .words(r_q.words)
);

// File: tb/rx_ring_engine_test.sv
module rx_ring_engine_test;
    localparam int BW = 8;
    localparam logic [23:0] BASE = 24'h000100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mem_req, mem_we, mem_ack, in_ready, irq_rx, irq_full;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, in_data;
    logic in_valid, in_last, in_err, in_tag, irq_rx_ack, irq_full_ack;
    logic [1:0] in_tail;
    logic [2:0] in_port;

    int checks = 0, fails = 0;
    logic [31:0] mem [0:1023];
    logic [23:0] exp_ptr;

    typedef struct { logic we; logic [23:0] addr; logic [31:0] data; string rq; } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    rx_ring_engine #(.BUF_WORDS(BW)) uut (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .in_tail(in_tail), .in_port(in_port), .in_err(in_err), .in_tag(in_tag),
        .irq_rx(irq_rx), .irq_rx_ack(irq_rx_ack), .irq_full(irq_full), .irq_full_ack(irq_full_ack)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6 actual=unexpected access %h expected=none", mem_addr);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk({e.rq, " kind"}, {31'd0, mem_we}, {31'd0, e.we});
                chk({e.rq, " addr"}, {8'd0, mem_addr}, {8'd0, e.addr});
                if (e.we) chk({e.rq, " data"}, mem_wdata, e.data);
            end
        end else mem_ack <= 1'b0;
    end

    task automatic push(logic we, logic [23:0] a, logic [31:0] d, string rq);
        item_t e;
        e.we = we; e.addr = a; e.data = d; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic send_frame(int nb, int tail, int port, bit err, bit tag, int seed);
        logic [31:0] w0, st;
        int bytes, len;
        w0 = mem[exp_ptr[11:2]];
        push(1'b0, exp_ptr, 32'd0, "R2");
        if (w0[31]) begin
            for (int i = 0; i < nb && i < BW; i++)
                push(1'b1, w0[23:0] + 24'(4 * i), 32'hA000_0000 + 32'(seed * 256 + i), "R2");
            bytes = 4 * (nb - 1) + ((tail == 0) ? 4 : tail);
            len   = (bytes > BW * 4) ? BW * 4 : bytes;
            st = '0;
            st[26:16] = 11'(len);
            st[14:12] = 3'(port);
            st[3] = err || (nb > BW);
            st[2] = tag;
            push(1'b1, exp_ptr + 24'd12, st, (nb > BW) ? "R7" : "R3");
            push(1'b1, exp_ptr, w0 & 32'h7FFF_FFFF, "R4");
            exp_ptr = w0[28] ? BASE : exp_ptr + 24'd16;
        end
        for (int i = 0; i < nb; i++) begin
            logic r;
            in_valid = 1'b1;
            in_data  = 32'hA000_0000 + 32'(seed * 256 + i);
            in_last  = (i == nb - 1);
            in_tail  = 2'(tail);
            in_port  = 3'(port);
            in_err   = err;
            in_tag   = tag;
            do begin
                #1 r = in_ready;
                @(negedge clk);
            end while (!r);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        in_valid = 0; in_data = 0; in_last = 0; in_tail = 0; in_port = 0;
        in_err = 0; in_tag = 0; irq_rx_ack = 0; irq_full_ack = 0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[BASE[11:2]]       = 32'h8000_0400;
        mem[BASE[11:2] + 4]   = 32'h8000_0600;
        mem[BASE[11:2] + 8]   = 32'h9000_0800;
        exp_ptr = BASE;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 in_ready", {31'd0, in_ready}, 32'd0);
        chk("R1 irq", {30'd0, irq_rx, irq_full}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3: three words, tail 2, tag set
        send_frame(3, 2, 5, 1'b0, 1'b1, 1);
        chk("R8 irq_rx set", {31'd0, irq_rx}, 32'd1);
        repeat (5) @(negedge clk);
        chk("R8 irq_rx held", {31'd0, irq_rx}, 32'd1);
        irq_rx_ack = 1'b1; @(negedge clk); irq_rx_ack = 1'b0;
        chk("R8 irq_rx cleared", {31'd0, irq_rx}, 32'd0);

        // R3 R5: single word with error, next descriptor
        send_frame(1, 0, 2, 1'b1, 1'b0, 2);
        irq_rx_ack = 1'b1; @(negedge clk); irq_rx_ack = 1'b0;

        // R7: longer than buffer, ring-end descriptor
        send_frame(10, 0, 7, 1'b0, 1'b0, 3);
        chk("R5 wrap ptr", {8'd0, exp_ptr}, {8'd0, BASE});
        irq_rx_ack = 1'b1; @(negedge clk); irq_rx_ack = 1'b0;

        // R6: base descriptor now released, frame dropped
        send_frame(2, 0, 1, 1'b0, 1'b0, 4);
        chk("R6 irq_full set", {31'd0, irq_full}, 32'd1);
        chk("R6 irq_rx quiet", {31'd0, irq_rx}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R9 irq_full held", {31'd0, irq_full}, 32'd1);
        irq_full_ack = 1'b1; @(negedge clk); irq_full_ack = 1'b0;
        chk("R9 irq_full cleared", {31'd0, irq_full}, 32'd0);

        // R5 R6: hand the base descriptor back; same descriptor is reused
        mem[BASE[11:2]] = mem[BASE[11:2]] | 32'h8000_0000;
        send_frame(2, 3, 4, 1'b0, 1'b1, 5);
        chk("R8 irq_rx again", {31'd0, irq_rx}, 32'd1);
        chk("R4 base released", mem[BASE[11:2]], 32'h0000_0400);
        summary();
    end
endmodule